// File: doc/BRIEF.md
# Phase Slew and Step Controller

This block turns a signed phase-offset measurement into corrections for a local time-of-day clock. Each new offset is latched when its valid strobe arrives. On every oscillator tick the controller then corrects the clock in one of three ways, chosen by the size of the pending offset. A large offset is slewed by moving a signed clock-adjust value `x` a fixed amount per tick. A small offset is absorbed in one go as a proportional trim of `x`. An offset beyond a second, larger threshold makes the controller ask the surrounding clock logic to jump its reading outright.

After each tick the block hands the prescaler the amount to add (base tick increment plus `x`). It also runs a saturating one-second hold-off counter. This counter throws away a correction once the correction has gone unrefreshed for too long. A previously saved `x` can be loaded back after a restart. The first offset after reset is never allowed to cause a jump. This keeps a bad initial measurement from wrecking the clock reading.

Top module: `phase_slew_ctrl`

## Requirements
- R1: After reset `x_o`, `wd_o`, `pre_add_o`, `pre_add_vld_o`, `step_req_o` and `hist_clr_o` are all zero.
- R2: On a tick whose pending offset magnitude is at or above `cfg_max_i`, `x_o` moves by `cfg_adjust_i`, up for a positive offset and down for a negative one. The offset stays pending, so each further tick repeats the move.
- R3: On a tick whose pending offset is nonzero with magnitude below `cfg_max_i`, `x_o` becomes the offset arithmetically shifted right by `cfg_phi_shift_i`, which rounds toward minus infinity. The pending offset is then cleared.
- R4: One cycle after each tick, `pre_add_vld_o` is 1 and `pre_add_o` equals `cfg_tick_i` plus the updated `x_o`. On cycles that follow no tick, `pre_add_vld_o` is 0.
- R5: The first offset strobe after reset never raises `step_req_o` or `hist_clr_o`, whatever its size. That offset is kept as the pending offset.
- R6: A later offset that is nonzero with magnitude at or above `cfg_maxstep_i` does the following for one cycle: raises `step_req_o` and `hist_clr_o`, shows the offset on `step_amt_o`, and clears `wd_o`. The offset is discarded rather than kept pending.
- R7: Every write of `x` by a tick (R2, R3) or by a load clears `wd_o` to zero.
- R8: Each `pps_i` pulse advances `wd_o` by one. The counter stops at `cfg_holdtc_i` and does not wrap.
- R9: While `wd_o` is at or above `cfg_holdtc_i`, `x_o` is forced to zero on the next cycle unless a load or tick write happens in that cycle. The forcing does not clear `wd_o`.
- R10: `load_i` sets `x_o` to `load_x_i` and takes priority over a tick in the same cycle. A slew offset that is pending stays pending.
- R11: A tick with no pending offset leaves `x_o` and `wd_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Oscillator tick strobe |
| pps_i | input | 1 | One-second pulse |
| ofs_vld_i | input | 1 | New offset available |
| ofs_theta_i | input | THETA_W | Signed phase offset |
| load_i | input | 1 | Load a saved clock-adjust value |
| load_x_i | input | X_W | Value to load into x |
| cfg_tick_i | input | X_W | Base prescaler increment per tick |
| cfg_max_i | input | THETA_W | Slew/trim magnitude threshold |
| cfg_maxstep_i | input | THETA_W | Step magnitude threshold |
| cfg_adjust_i | input | ADJ_W | Slew increment per tick |
| cfg_phi_shift_i | input | SH_W | Trim right-shift amount |
| cfg_holdtc_i | input | WD_W | Hold-off limit in seconds |
| x_o | output | X_W | Signed clock-adjust value |
| pre_add_o | output | X_W | Prescaler add term |
| pre_add_vld_o | output | 1 | Prescaler add term valid |
| step_req_o | output | 1 | Step request pulse |
| step_amt_o | output | THETA_W | Signed step amount |
| hist_clr_o | output | 1 | Compliance history reset pulse |
| wd_o | output | WD_W | Hold-off counter |

## Verification
Every result sits exactly one clock edge behind the strobe that causes it:
- a tick's new `x_o` and its prescaler term;
- an offset strobe's step pulse, history clear and step amount;
- a load;
- a one-second pulse's counter value.

The forced clearing of `x_o` is the one exception. It lands one edge after the counter reaches its limit, which is two edges after the last second pulse. The bench drives a strobe on a falling edge and releases it on the next falling edge, reading the outputs at that moment, so exactly one rising edge separates the two. For the hold-off case it idles extra cycles before reading.

// File: rtl/psc_pkg.sv
package psc_pkg;

  typedef enum logic [1:0] {
    RG_IDLE = 2'd0,
    RG_SLEW = 2'd1,
    RG_TRIM = 2'd2
  } psc_regime_e;

endpackage

// File: rtl/psc_mag_cmp.sv
module psc_mag_cmp #(
  parameter int W = 32
) (
  input  logic signed [W-1:0] val_i,
  input  logic        [W-1:0] thr_i,
  output logic                ge_o,
  output logic                nz_o
);

  logic [W-1:0] mag;

  // magnitude as unsigned: the most negative value maps to 2^(W-1) exactly
  always_comb begin
    mag  = val_i[W-1] ? (~val_i + 1'b1) : val_i;
    ge_o = (mag >= thr_i);
    nz_o = (val_i != '0);
  end

endmodule

// File: rtl/psc_watchdog.sv
module psc_watchdog #(
  parameter int WD_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            pps_i,
  input  logic [WD_W-1:0] holdtc_i,
  output logic [WD_W-1:0] wd_o,
  output logic            expired_o
);

  logic [WD_W-1:0] wd_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_r <= '0;
    end else if (clr_i) begin
      wd_r <= '0;
    end else if (pps_i && (wd_r < holdtc_i)) begin
      wd_r <= wd_r + 1'b1;
    end
  end

  assign wd_o      = wd_r;
  assign expired_o = (wd_r >= holdtc_i);

  AST_WD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (wd_o == '0)); // R7

  AST_WD_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && expired_o && $stable(holdtc_i)) |=> $stable(wd_o)); // R8

  AST_WD_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && pps_i && (wd_o < holdtc_i)) |=> (wd_o == $past(wd_o) + 1'b1)); // R8

endmodule

// File: rtl/psc_xreg.sv
module psc_xreg
  import psc_pkg::*;
#(
  parameter int X_W     = 32,
  parameter int THETA_W = 32,
  parameter int ADJ_W   = 16,
  parameter int SH_W    = $clog2(X_W)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick_i,
  input  psc_regime_e               regime_i,
  input  logic signed [THETA_W-1:0] theta_i,
  input  logic                      load_i,
  input  logic        [X_W-1:0]     load_x_i,
  input  logic                      expired_i,
  input  logic        [X_W-1:0]     cfg_tick_i,
  input  logic        [ADJ_W-1:0]   cfg_adjust_i,
  input  logic        [SH_W-1:0]    cfg_phi_shift_i,
  output logic                      x_wr_o,
  output logic signed [X_W-1:0]     x_o,
  output logic        [X_W-1:0]     pre_add_o,
  output logic                      pre_add_vld_o
);

  logic signed [X_W-1:0] x_r;
  logic signed [X_W-1:0] x_nxt;
  logic signed [X_W-1:0] theta_ext;
  logic signed [X_W-1:0] adj_ext;
  logic        [X_W-1:0] pre_add_r;
  logic                  pre_vld_r;
  logic                  wr;

  always_comb begin
    theta_ext = X_W'(theta_i);
    adj_ext   = X_W'(cfg_adjust_i);
    x_nxt     = x_r;
    wr        = 1'b0;
    if (load_i) begin
      x_nxt = load_x_i;
      wr    = 1'b1;
    end else if (tick_i && (regime_i == RG_SLEW)) begin
      x_nxt = theta_i[THETA_W-1] ? (x_r - adj_ext) : (x_r + adj_ext);
      wr    = 1'b1;
    end else if (tick_i && (regime_i == RG_TRIM)) begin
      x_nxt = theta_ext >>> cfg_phi_shift_i;
      wr    = 1'b1;
    end else if (expired_i) begin
      x_nxt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_r       <= '0;
      pre_add_r <= '0;
      pre_vld_r <= 1'b0;
    end else begin
      x_r       <= x_nxt;
      pre_vld_r <= tick_i;
      if (tick_i) begin
        pre_add_r <= cfg_tick_i + x_nxt;
      end
    end
  end

  assign x_wr_o        = wr;
  assign x_o           = x_r;
  assign pre_add_o     = pre_add_r;
  assign pre_add_vld_o = pre_vld_r;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (x_o == $past(load_x_i))); // R10

  AST_IDLE_TICK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!load_i && tick_i && (regime_i == RG_IDLE) && !expired_i) |=> $stable(x_o)); // R11

  AST_SLEW_UP: assert property (@(posedge clk) disable iff (rst)
    (!load_i && tick_i && (regime_i == RG_SLEW) && !theta_i[THETA_W-1])
      |=> (x_o == $past(x_o) + $past(adj_ext))); // R2

  AST_TICK_VALID: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> (pre_add_vld_o && (pre_add_o == $past(cfg_tick_i) + x_o))); // R4

  AST_HOLDOFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !tick_i && expired_i) |=> (x_o == '0)); // R9

endmodule

// File: rtl/phase_slew_ctrl.sv
module phase_slew_ctrl
  import psc_pkg::*;
#(
  parameter int X_W     = 32,
  parameter int THETA_W = 32,
  parameter int ADJ_W   = 16,
  parameter int WD_W    = 16,
  parameter int SH_W    = $clog2(X_W)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick_i,
  input  logic                      pps_i,
  input  logic                      ofs_vld_i,
  input  logic signed [THETA_W-1:0] ofs_theta_i,
  input  logic                      load_i,
  input  logic        [X_W-1:0]     load_x_i,
  input  logic        [X_W-1:0]     cfg_tick_i,
  input  logic        [THETA_W-1:0] cfg_max_i,
  input  logic        [THETA_W-1:0] cfg_maxstep_i,
  input  logic        [ADJ_W-1:0]   cfg_adjust_i,
  input  logic        [SH_W-1:0]    cfg_phi_shift_i,
  input  logic        [WD_W-1:0]    cfg_holdtc_i,
  output logic signed [X_W-1:0]     x_o,
  output logic        [X_W-1:0]     pre_add_o,
  output logic                      pre_add_vld_o,
  output logic                      step_req_o,
  output logic signed [THETA_W-1:0] step_amt_o,
  output logic                      hist_clr_o,
  output logic        [WD_W-1:0]    wd_o
);

  logic signed [THETA_W-1:0] theta_r;
  logic                      first_r;
  logic                      step_r;
  logic signed [THETA_W-1:0] step_amt_r;
  logic                      hist_clr_r;

  logic        pend_ge, pend_nz;
  logic        new_ge, new_nz;
  logic        step_fire;
  logic        x_wr;
  logic        expired;
  psc_regime_e regime;

  psc_mag_cmp #(.W(THETA_W)) u_pend_cmp (
    .val_i (theta_r),
    .thr_i (cfg_max_i),
    .ge_o  (pend_ge),
    .nz_o  (pend_nz)
  );

  psc_mag_cmp #(.W(THETA_W)) u_step_cmp (
    .val_i (ofs_theta_i),
    .thr_i (cfg_maxstep_i),
    .ge_o  (new_ge),
    .nz_o  (new_nz)
  );

  always_comb begin
    if (!pend_nz)     regime = RG_IDLE;
    else if (pend_ge) regime = RG_SLEW;
    else              regime = RG_TRIM;
  end

  assign step_fire = ofs_vld_i && !first_r && new_ge && new_nz;

  // pending offset: a new strobe wins over a trim that consumes the old one
  always_ff @(posedge clk) begin
    if (rst) begin
      theta_r <= '0;
      first_r <= 1'b1;
    end else begin
      if (ofs_vld_i) begin
        theta_r <= step_fire ? '0 : ofs_theta_i;
        first_r <= 1'b0;
      end else if (tick_i && !load_i && (regime == RG_TRIM)) begin
        theta_r <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_r     <= 1'b0;
      step_amt_r <= '0;
      hist_clr_r <= 1'b0;
    end else begin
      step_r     <= step_fire;
      hist_clr_r <= step_fire;
      if (step_fire) begin
        step_amt_r <= ofs_theta_i;
      end
    end
  end

  psc_watchdog #(.WD_W(WD_W)) u_wd (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (x_wr | step_fire),
    .pps_i     (pps_i),
    .holdtc_i  (cfg_holdtc_i),
    .wd_o      (wd_o),
    .expired_o (expired)
  );

  psc_xreg #(
    .X_W     (X_W),
    .THETA_W (THETA_W),
    .ADJ_W   (ADJ_W),
    .SH_W    (SH_W)
  ) u_x (
    .clk             (clk),
    .rst             (rst),
    .tick_i          (tick_i),
    .regime_i        (regime),
    .theta_i         (theta_r),
    .load_i          (load_i),
    .load_x_i        (load_x_i),
    .expired_i       (expired),
    .cfg_tick_i      (cfg_tick_i),
    .cfg_adjust_i    (cfg_adjust_i),
    .cfg_phi_shift_i (cfg_phi_shift_i),
    .x_wr_o          (x_wr),
    .x_o             (x_o),
    .pre_add_o       (pre_add_o),
    .pre_add_vld_o   (pre_add_vld_o)
  );

  assign step_req_o = step_r;
  assign step_amt_o = step_amt_r;
  assign hist_clr_o = hist_clr_r;

  AST_NO_FIRST_STEP: assert property (@(posedge clk) disable iff (rst)
    (ofs_vld_i && first_r) |=> (!step_req_o && !hist_clr_o)); // R5

  AST_STEP_CLEARS_WD: assert property (@(posedge clk) disable iff (rst)
    step_req_o |-> (wd_o == '0)); // R6

  AST_STEP_DROPS_THETA: assert property (@(posedge clk) disable iff (rst)
    step_req_o |-> (theta_r == '0)); // R6

endmodule

// File: tb/phase_slew_ctrl_tb.sv
module phase_slew_ctrl_tb_top;

  localparam int X_W     = 32;
  localparam int THETA_W = 32;
  localparam int ADJ_W   = 16;
  localparam int WD_W    = 16;
  localparam int SH_W    = $clog2(X_W);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic                      tick, pps, ofs_vld, load;
  logic signed [THETA_W-1:0] theta;
  logic        [X_W-1:0]     load_x;
  logic signed [X_W-1:0]     x_o;
  logic        [X_W-1:0]     pre_add;
  logic                      pre_vld, step_req, hist_clr;
  logic signed [THETA_W-1:0] step_amt;
  logic        [WD_W-1:0]    wd;

  localparam logic [X_W-1:0]     C_TICK    = 32'd1000;
  localparam logic [THETA_W-1:0] C_MAX     = 32'd128;
  localparam logic [THETA_W-1:0] C_MAXSTEP = 32'd1000000;
  localparam logic [ADJ_W-1:0]   C_ADJ     = 16'd8;
  localparam logic [SH_W-1:0]    C_SHIFT   = 5'd4;
  localparam logic [WD_W-1:0]    C_HOLD    = 16'd5;

  phase_slew_ctrl #(
    .X_W(X_W), .THETA_W(THETA_W), .ADJ_W(ADJ_W), .WD_W(WD_W), .SH_W(SH_W)
  ) dut_i (
    .clk             (clk),
    .rst             (rst),
    .tick_i          (tick),
    .pps_i           (pps),
    .ofs_vld_i       (ofs_vld),
    .ofs_theta_i     (theta),
    .load_i          (load),
    .load_x_i        (load_x),
    .cfg_tick_i      (C_TICK),
    .cfg_max_i       (C_MAX),
    .cfg_maxstep_i   (C_MAXSTEP),
    .cfg_adjust_i    (C_ADJ),
    .cfg_phi_shift_i (C_SHIFT),
    .cfg_holdtc_i    (C_HOLD),
    .x_o             (x_o),
    .pre_add_o       (pre_add),
    .pre_add_vld_o   (pre_vld),
    .step_req_o      (step_req),
    .step_amt_o      (step_amt),
    .hist_clr_o      (hist_clr),
    .wd_o            (wd)
  );

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one strobe cycle from a falling edge; outputs are read at the next falling edge
  task automatic cyc(input bit t, input bit p, input bit v,
                     input longint th, input bit ld, input longint lx);
    tick = t; pps = p; ofs_vld = v; theta = THETA_W'(th); load = ld; load_x = X_W'(lx);
    @(negedge clk);
    tick = 0; pps = 0; ofs_vld = 0; load = 0;
  endtask

  task automatic do_tick();   cyc(1, 0, 0, 0, 0, 0); endtask
  task automatic do_pps();    cyc(0, 1, 0, 0, 0, 0); endtask
  task automatic do_idle();   cyc(0, 0, 0, 0, 0, 0); endtask
  task automatic do_ofs(input longint th); cyc(0, 0, 1, th, 0, 0); endtask

  task automatic t_reset();
    check("R1", "x", longint'(x_o), 0);
    check("R1", "wd", longint'(wd), 0);
    check("R1", "pre_add", longint'(pre_add), 0);
    check("R1", "pre_vld", longint'(pre_vld), 0);
    check("R1", "step_req", longint'(step_req), 0);
    check("R1", "hist_clr", longint'(hist_clr), 0);
  endtask

  task automatic t_first_update();
    do_ofs(2000000);
    check("R5", "step_req on first", longint'(step_req), 0);
    check("R5", "hist_clr on first", longint'(hist_clr), 0);
    do_tick();
    check("R2", "slew up x", longint'(x_o), 8);
    check("R4", "pre_add", longint'(pre_add), 1008);
    check("R4", "pre_vld", longint'(pre_vld), 1);
    do_idle();
    check("R4", "pre_vld idle", longint'(pre_vld), 0);
    do_tick();
    check("R2", "slew repeat x", longint'(x_o), 16);
  endtask

  task automatic t_step();
    do_pps(); do_pps();
    check("R8", "wd after 2 pps", longint'(wd), 2);
    do_ofs(-3000000);
    check("R6", "step_req", longint'(step_req), 1);
    check("R6", "step_amt", longint'(step_amt), -3000000);
    check("R6", "hist_clr", longint'(hist_clr), 1);
    check("R6", "wd cleared", longint'(wd), 0);
    do_idle();
    check("R6", "step_req one cycle", longint'(step_req), 0);
    do_tick();
    check("R6", "theta discarded x", longint'(x_o), 16);
    check("R11", "idle tick pre_add", longint'(pre_add), 1016);
    do_ofs(999999);
    check("R6", "below step threshold", longint'(step_req), 0);
    do_ofs(1000000);
    check("R6", "at step threshold", longint'(step_req), 1);
    check("R6", "step_amt at threshold", longint'(step_amt), 1000000);
  endtask

  task automatic t_slew_neg();
    do_ofs(-500);
    do_tick(); check("R2", "slew down 1", longint'(x_o), 8);
    do_tick(); check("R2", "slew down 2", longint'(x_o), 0);
    do_tick(); check("R2", "slew down 3", longint'(x_o), -8);
  endtask

  task automatic t_trim();
    do_ofs(-100);
    do_tick();
    check("R3", "trim negative floor", longint'(x_o), -7);
    check("R4", "pre_add negative x", longint'(pre_add), 993);
    do_tick();
    check("R3", "trim consumed", longint'(x_o), -7);
    do_ofs(100);
    do_tick();
    check("R3", "trim positive", longint'(x_o), 6);
    do_ofs(128);
    do_tick(); check("R2", "at max slews", longint'(x_o), 14);
    do_tick(); check("R2", "at max held", longint'(x_o), 22);
    do_ofs(127);
    do_tick(); check("R3", "below max trims", longint'(x_o), 7);
    do_ofs(-128);
    do_tick(); check("R2", "at -max slews", longint'(x_o), -1);
  endtask

  task automatic t_holdoff();
    do_ofs(0);
    for (int i = 0; i < 3; i++) do_pps();
    check("R8", "wd counts", longint'(wd), 3);
    do_tick();
    check("R11", "idle tick keeps x", longint'(x_o), -1);
    check("R11", "idle tick keeps wd", longint'(wd), 3);
    for (int i = 0; i < 5; i++) do_pps();
    check("R8", "wd saturates", longint'(wd), 5);
    check("R9", "x forced zero", longint'(x_o), 0);
    do_idle();
    check("R9", "wd kept after force", longint'(wd), 5);
  endtask

  task automatic t_load();
    do_ofs(500);
    cyc(1, 0, 0, 0, 1, 12345);
    check("R10", "load beats tick", longint'(x_o), 12345);
    check("R7", "load clears wd", longint'(wd), 0);
    check("R4", "pre_add after load", longint'(pre_add), 13345);
    do_tick();
    check("R10", "slew kept pending", longint'(x_o), 12353);
  endtask

  task automatic t_trim_clears_wd();
    do_pps(); do_pps();
    check("R8", "wd before trim", longint'(wd), 2);
    do_ofs(100);
    do_tick();
    check("R3", "trim value", longint'(x_o), 6);
    check("R7", "trim clears wd", longint'(wd), 0);
  endtask

  initial begin
    tick = 0; pps = 0; ofs_vld = 0; load = 0; theta = '0; load_x = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_update();
    t_step();
    t_slew_neg();
    t_trim();
    t_holdoff();
    t_load();
    t_trim_clears_wd();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule